// File: doc/BRIEF.md
# Tone-Pair Steering and Guard-Time Validator

This block sits behind a dual-tone frequency detector and decides when a detected tone pair counts as a key press. The detector raises a level, `early_det`, for as long as both tones of a pair are present, and reports which row tone and column tone it found. The validator accepts a key only when that level has stayed high for a programmable number of clock cycles, the tone-present guard time. On acceptance it stores the 4-bit key code and raises `guard_out`. A fixed number of cycles later it raises the delayed-steering flag `dly_steer`, so the code is already stable when the flag is seen. `new_digit` pulses for one cycle at that moment.

The digit ends only after `early_det` has stayed low for a second programmable count, the tone-absent guard time. A shorter gap counts as a dropout inside the same tone. The stored code is not touched, and the flag and pulse do not repeat. The two counts give hysteresis in both directions. Short bursts such as speech are rejected, and short dropouts are bridged. Seen from the line, the shortest recognised tone is the detector's own acquisition delay plus the tone-present guard time. The shortest interdigit pause is the detector's release delay plus the tone-absent guard time.

The code bus models a tri-state output as an enable plus data that reads zero while the enable is low. Downstream logic reads the code when the flag is high, or on the `new_digit` pulse.

Top module: `tone_steer`

## Requirements
- R1: While `rst` is high at a clock edge, every state element clears. After that edge `guard_out`, `dly_steer` and `new_digit` are low, and the stored code is 0000. Reset is synchronous and active high.
- R2: A key is registered at the clock edge where `early_det` has been sampled high on N consecutive edges. N is `present_guard`, and a value of 0 acts as 1. `guard_out` is high from that edge on.
- R3: A run of `early_det` high shorter than the tone-present guard time registers nothing. `guard_out` and `dly_steer` stay low, and the stored code keeps its earlier value.
- R4: At registration the code is taken from `row` and `col`. Rows 0..3 are 697/770/852/941 Hz, and columns 0..3 are 1209/1336/1477/1633 Hz. The keys '1'..'9' give binary 1..9. '0' gives 1010, '*' gives 1011, '#' gives 1100, 'A', 'B' and 'C' give 1101, 1110 and 1111, and 'D' gives 0000. The key layout is: row 0 holds 1 2 3 A, row 1 holds 4 5 6 B, row 2 holds 7 8 9 C, and row 3 holds * 0 # D.
- R5: While a digit is registered, changes on `row` and `col` do not change the stored code.
- R6: While a digit is registered, `guard_out` after each edge equals the `early_det` value sampled at that edge. At all other times it is low.
- R7: `dly_steer` rises at the edge SETTLE_CYCLES (default 2) edges after the edge at which `guard_out` first rose for the digit, provided the digit is still registered at that edge.
- R8: A low gap in `early_det` shorter than the tone-absent guard time leaves `dly_steer` high and the stored code unchanged, and it does not produce another `new_digit` pulse.
- R9: A registered digit ends, and `dly_steer` falls, at the edge where `early_det` has been sampled low on M consecutive edges. M is `absent_guard`, and a value of 0 acts as 1.
- R10: `new_digit` is high for exactly the one cycle in which `dly_steer` has just risen.
- R11: `code_oe` equals `out_en`. `code_out` carries the stored code while `out_en` is high and reads 0000 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| early_det | input | 1 | High while the detector sees a valid tone pair |
| row | input | 2 | Index of the detected low-group tone |
| col | input | 2 | Index of the detected high-group tone |
| present_guard | input | CNT_W (16) | Tone-present guard time in cycles |
| absent_guard | input | CNT_W (16) | Tone-absent guard time in cycles |
| out_en | input | 1 | Code bus output enable |
| code_out | output | 4 | Stored key code, zero while the bus is disabled |
| code_oe | output | 1 | Bus drive enable, follows out_en |
| guard_out | output | 1 | Guard output, follows early_det while a digit is held |
| dly_steer | output | 1 | Delayed steering flag |
| new_digit | output | 1 | One-cycle pulse on the rising edge of dly_steer |

## Verification
The bench targets bursts that end exactly one cycle short of the present guard. A timer off by one would accept them and report a phantom key. It also places dropouts one cycle shorter than the absent guard inside a held tone. A design that restarts the digit there would pulse `new_digit` twice or re-latch a changed row and column. Guard values of zero are exercised as well, because a naive compare would never expire or would fire at once. Finally, the bench lets a digit end before its settle delay completes. This exposes a flag that rises without a registered digit, or a pulse that fires during release.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

    // Width of the key code produced for a row/column tone pair.
    localparam int unsigned KEY_W = 4;

    // Steering state: no digit, digit held with tone present, digit held
    // across a low gap that has not yet lasted the absent guard time.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_BRIDGE = 2'd2
    } steer_state_e;

endpackage

// File: rtl/tone_key_encoder.sv
module tone_key_encoder
    import tone_steer_pkg::*;
(
    input  logic [1:0]       row,
    input  logic [1:0]       col,
    output logic [KEY_W-1:0] key_code
);

    // Numeric keys occupy rows 0..2, columns 0..2 and count up from 1.
    // Column 3 holds the letters; row 3 holds *, 0, # and D.
    always_comb begin
        key_code = '0;
        if (col == 2'd3) begin
            case (row)
                2'd0:    key_code = KEY_W'(13);
                2'd1:    key_code = KEY_W'(14);
                2'd2:    key_code = KEY_W'(15);
                default: key_code = KEY_W'(0);
            endcase
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    key_code = KEY_W'(11);
                2'd1:    key_code = KEY_W'(10);
                default: key_code = KEY_W'(12);
            endcase
        end else begin
            key_code = KEY_W'({2'b00, row} * 3 + {2'b00, col} + 4'd1);
        end
    end

endmodule

// File: rtl/tone_steer_fsm.sv
module tone_steer_fsm
    import tone_steer_pkg::*;
#(
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned SETTLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             early_det,
    input  logic [KEY_W-1:0] key_code,
    input  logic [CNT_W-1:0] present_guard,
    input  logic [CNT_W-1:0] absent_guard,
    output logic [KEY_W-1:0] code_q_o,
    output logic             guard_o,
    output logic             flag_o,
    output logic             pulse_o
);

    // SETTLE_CYCLES must be at least 1.
    localparam int unsigned SET_W = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        steer_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic [SET_W-1:0] settle;
        logic [KEY_W-1:0] code;
        logic             guard;
        logic             flag;
        logic             pulse;
    } steer_regs_t;

    steer_regs_t cur_q, nxt_d;

    logic [CNT_W-1:0] eff_present_d;
    logic [CNT_W-1:0] eff_absent_d;
    logic [CNT_W:0]   cnt_inc_d;
    logic [SET_W:0]   settle_inc_d;

    always_comb begin
        eff_present_d = (present_guard == '0) ? CNT_W'(1) : present_guard;
        eff_absent_d  = (absent_guard  == '0) ? CNT_W'(1) : absent_guard;
        cnt_inc_d     = {1'b0, cur_q.cnt} + 1'b1;
        settle_inc_d  = {1'b0, cur_q.settle} + 1'b1;

        nxt_d       = cur_q;
        nxt_d.pulse = 1'b0;

        case (cur_q.state)
            ST_HELD, ST_BRIDGE: begin
                // Settle delay toward the steering flag.
                if (!cur_q.flag) begin
                    if (settle_inc_d >= (SET_W+1)'(SETTLE_CYCLES)) begin
                        nxt_d.flag  = 1'b1;
                        nxt_d.pulse = 1'b1;
                    end else begin
                        nxt_d.settle = settle_inc_d[SET_W-1:0];
                    end
                end
                if (early_det) begin
                    nxt_d.state = ST_HELD;
                    nxt_d.guard = 1'b1;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.guard = 1'b0;
                    if (cnt_inc_d >= {1'b0, eff_absent_d}) begin
                        // Pause long enough: the digit ends; release wins
                        // over a flag rise in the same cycle.
                        nxt_d.state  = ST_IDLE;
                        nxt_d.cnt    = '0;
                        nxt_d.settle = '0;
                        nxt_d.flag   = 1'b0;
                        nxt_d.pulse  = 1'b0;
                    end else begin
                        nxt_d.state = ST_BRIDGE;
                        nxt_d.cnt   = cnt_inc_d[CNT_W-1:0];
                    end
                end
            end
            default: begin
                nxt_d.guard = 1'b0;
                nxt_d.flag  = 1'b0;
                if (early_det) begin
                    if (cnt_inc_d >= {1'b0, eff_present_d}) begin
                        nxt_d.state  = ST_HELD;
                        nxt_d.code   = key_code;
                        nxt_d.guard  = 1'b1;
                        nxt_d.cnt    = '0;
                        nxt_d.settle = '0;
                    end else begin
                        nxt_d.cnt = cnt_inc_d[CNT_W-1:0];
                    end
                end else begin
                    nxt_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: ST_IDLE, cnt: '0, settle: '0, code: '0,
                       guard: 1'b0, flag: 1'b0, pulse: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign code_q_o = cur_q.code;
    assign guard_o  = cur_q.guard;
    assign flag_o   = cur_q.flag;
    assign pulse_o  = cur_q.pulse;

endmodule

// File: rtl/tone_bus_gate.sv
module tone_bus_gate
    import tone_steer_pkg::*;
(
    input  logic             out_en,
    input  logic [KEY_W-1:0] code_in,
    output logic [KEY_W-1:0] code_out,
    output logic             code_oe
);

    for (genvar b = 0; b < KEY_W; b++) begin : g_bit
        assign code_out[b] = code_in[b] & out_en;
    end

    assign code_oe = out_en;

endmodule

// File: rtl/tone_steer.sv
module tone_steer
    import tone_steer_pkg::*;
#(
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned SETTLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             early_det,
    input  logic [1:0]       row,
    input  logic [1:0]       col,
    input  logic [CNT_W-1:0] present_guard,
    input  logic [CNT_W-1:0] absent_guard,
    input  logic             out_en,
    output logic [KEY_W-1:0] code_out,
    output logic             code_oe,
    output logic             guard_out,
    output logic             dly_steer,
    output logic             new_digit
);

    logic [KEY_W-1:0] key_code;
    logic [KEY_W-1:0] code_held;

    tone_key_encoder u_enc (
        .row      (row),
        .col      (col),
        .key_code (key_code)
    );

    tone_steer_fsm #(
        .CNT_W         (CNT_W),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .early_det     (early_det),
        .key_code      (key_code),
        .present_guard (present_guard),
        .absent_guard  (absent_guard),
        .code_q_o      (code_held),
        .guard_o       (guard_out),
        .flag_o        (dly_steer),
        .pulse_o       (new_digit)
    );

    tone_bus_gate u_bus (
        .out_en   (out_en),
        .code_in  (code_held),
        .code_out (code_out),
        .code_oe  (code_oe)
    );

endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       early_det,
    input logic       out_en,
    input logic [3:0] code_out,
    input logic       code_oe,
    input logic       guard_out,
    input logic       dly_steer,
    input logic       new_digit
);

    // R6: guard can only be high when the tone was present at the last edge.
    a_r6_guard_tracks_early: assert property (@(posedge clk) disable iff (rst)
        guard_out |-> $past(early_det));

    // R10: the pulse marks a fresh rise of the flag.
    a_r10_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        new_digit |-> (dly_steer && !$past(dly_steer)));

    // R10: the pulse lasts a single cycle.
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        new_digit |=> !new_digit);

    // R11: a disabled bus carries no data.
    a_r11_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (code_out == 4'd0 && !code_oe));

    // R5: the code seen on an enabled bus stays put while the flag is held.
    a_r5_code_stable: assert property (@(posedge clk) disable iff (rst)
        (dly_steer && $past(dly_steer) && out_en && $past(out_en)) |-> $stable(code_out));

    // R9: the flag only falls after a tone-absent sample.
    a_r9_fall_on_absence: assert property (@(posedge clk) disable iff (rst)
        $fell(dly_steer) |-> !$past(early_det));

endmodule

bind tone_steer tone_steer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .early_det (early_det),
    .out_en    (out_en),
    .code_out  (code_out),
    .code_oe   (code_oe),
    .guard_out (guard_out),
    .dly_steer (dly_steer),
    .new_digit (new_digit)
);

// File: tb/tone_steer_tb.sv
module tone_steer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int SETTLE     = 2;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             early_det = 1'b0;
    logic [1:0]       row = 2'd0;
    logic [1:0]       col = 2'd0;
    logic [CNT_W-1:0] present_guard = 16'd4;
    logic [CNT_W-1:0] absent_guard = 16'd3;
    logic             out_en = 1'b0;
    logic [3:0]       code_out;
    logic             code_oe;
    logic             guard_out;
    logic             dly_steer;
    logic             new_digit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    bit m_reg, m_g, m_f, m_p;
    int m_code, m_hi, m_lo, m_s;

    tone_steer #(.CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .early_det(early_det), .row(row), .col(col),
        .present_guard(present_guard), .absent_guard(absent_guard),
        .out_en(out_en), .code_out(code_out), .code_oe(code_oe),
        .guard_out(guard_out), .dly_steer(dly_steer), .new_digit(new_digit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic byte key_char(input int r, input int c);
        byte layout [0:15];
        layout = '{"1","2","3","A","4","5","6","B","7","8","9","C","*","0","#","D"};
        return layout[r*4 + c];
    endfunction

    function automatic int char_code(input byte k);
        case (k)
            "0": return 10;
            "*": return 11;
            "#": return 12;
            "A": return 13;
            "B": return 14;
            "C": return 15;
            "D": return 0;
            default: return int'(k) - int'("0");
        endcase
    endfunction

    function automatic int eff(input int g);
        return (g == 0) ? 1 : g;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Model update at each edge, followed by a per-cycle comparison.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_reg = 0; m_g = 0; m_f = 0; m_p = 0;
            m_code = 0; m_hi = 0; m_lo = 0; m_s = 0;
        end else begin
            m_p = 0;
            if (!m_reg) begin
                if (early_det) begin
                    m_hi++;
                    if (m_hi >= eff(int'(present_guard))) begin
                        m_reg = 1; m_g = 1; m_f = 0; m_s = 0; m_lo = 0;
                        m_code = char_code(key_char(int'(row), int'(col)));
                    end
                end else begin
                    m_hi = 0;
                end
            end else begin
                if (!m_f) begin
                    m_s++;
                    if (m_s >= SETTLE) begin m_f = 1; m_p = 1; end
                end
                if (early_det) begin
                    m_lo = 0; m_g = 1;
                end else begin
                    m_lo++; m_g = 0;
                    if (m_lo >= eff(int'(absent_guard))) begin
                        m_reg = 0; m_f = 0; m_p = 0; m_hi = 0;
                    end
                end
            end
        end
        #2;
        if (!rst) begin
            check("R6 guard_out", int'(guard_out), int'(m_g));
            check("R7/R9 dly_steer", int'(dly_steer), int'(m_f));
            check("R10 new_digit", int'(new_digit), int'(m_p));
            check("R11 code_oe", int'(code_oe), int'(out_en));
            check("R4/R11 code_out", int'(code_out), out_en ? m_code : 0);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #3;
        end
    endtask

    task automatic drive(input bit e, input int r, input int c, input bit oe);
        early_det = e; row = 2'(r); col = 2'(c); out_en = oe;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        tick(3);
        // R1: reset values
        check("R1 guard_out", int'(guard_out), 0);
        check("R1 dly_steer", int'(dly_steer), 0);
        check("R1 new_digit", int'(new_digit), 0);
        out_en = 1'b1;
        #1 check("R1 code", int'(code_out), 0);
        rst = 1'b0;
        tick(2);

        // R2: key '5' with a guard of 4
        drive(1, 1, 1, 1);
        tick(3);
        check("R2 early guard", int'(guard_out), 0);
        tick(1);
        check("R2 guard rise", int'(guard_out), 1);
        check("R7 flag not yet", int'(dly_steer), 0);
        tick(1);
        check("R7 flag not yet", int'(dly_steer), 0);
        tick(1);
        check("R7 flag rise", int'(dly_steer), 1);
        check("R10 pulse", int'(new_digit), 1);
        check("R4 code 5", int'(code_out), 5);
        // R5: detector indices change during the hold
        drive(1, 3, 3, 1);
        tick(1);
        check("R10 pulse gone", int'(new_digit), 0);
        check("R5 code kept", int'(code_out), 5);
        // R8: dropout of 2 with an absent guard of 3
        drive(0, 3, 3, 1);
        tick(2);
        check("R6 guard low", int'(guard_out), 0);
        check("R8 flag bridged", int'(dly_steer), 1);
        drive(1, 3, 3, 1);
        tick(1);
        check("R8 no repulse", int'(new_digit), 0);
        check("R8 code kept", int'(code_out), 5);
        // R9: a full pause ends the digit
        drive(0, 3, 3, 1);
        tick(2);
        check("R9 still held", int'(dly_steer), 1);
        tick(1);
        check("R9 flag cleared", int'(dly_steer), 0);
        // R11: disabled bus
        drive(0, 3, 3, 0);
        tick(1);
        check("R11 data zero", int'(code_out), 0);
        check("R11 oe low", int'(code_oe), 0);
        // R3: burst one cycle short of the guard, key '9'
        drive(1, 2, 2, 1);
        tick(3);
        check("R3 no guard", int'(guard_out), 0);
        drive(0, 2, 2, 1);
        tick(3);
        check("R3 no flag", int'(dly_steer), 0);
        check("R3 code kept", int'(code_out), 5);
        // R2: zero guard acts as one, key 'D'
        present_guard = 16'd0;
        drive(1, 3, 3, 1);
        tick(1);
        check("R2 zero guard", int'(guard_out), 1);
        check("R4 code D", int'(code_out), 0);
        drive(0, 3, 3, 1);
        tick(1);
        check("R9 early release", int'(dly_steer), 0);
        tick(3);
        // R4: key '*' with guard 1
        present_guard = 16'd1;
        drive(1, 3, 0, 1);
        tick(4);
        check("R4 code star", int'(code_out), 11);
        drive(0, 3, 0, 1);
        tick(4);

        // Random phase
        for (int seg = 0; seg < 900; seg++) begin
            int hi_len, lo_len, r, c;
            hi_len = 1 + int'($urandom_range(0, 7));
            lo_len = 1 + int'($urandom_range(0, 6));
            r = int'($urandom_range(0, 3));
            c = int'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) begin
                present_guard = CNT_W'($urandom_range(0, 5));
                absent_guard  = CNT_W'($urandom_range(0, 5));
            end
            for (int i = 0; i < hi_len; i++) begin
                drive(1, r, c, bit'($urandom_range(0, 1)));
                tick(1);
                if ($urandom_range(0, 3) == 0) begin r = int'($urandom_range(0, 3)); c = int'($urandom_range(0, 3)); end
            end
            for (int i = 0; i < lo_len; i++) begin
                drive(0, r, c, bit'($urandom_range(0, 1)));
                tick(1);
            end
        end
        finish_run();
    end

endmodule